// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block turns a clock ratio into I2C clock timing and then produces the SCL waveform from that timing. The ratio is the number of peripheral clock cycles in one bus clock period. A write strobe loads a new ratio. The block reduces the ratio to a power-of-two base divider plus a small residual ratio. It splits the residual into SCL low and high counts and keeps the result as a packed 32-bit timing word. It also raises a high-speed flag when the requested bus rate is above 400 kHz, and sets a two-bit timeout control value to match.

A second part runs SCL freely while the run input is high. A base tick fires once every 2^exponent peripheral clocks. SCL stays low for a whole number of ticks and then high for a whole number of ticks. A one-cycle strobe marks every falling edge and every rising edge, so a byte-level engine can place data changes and samples on them. A new configuration is latched only at the start of an SCL low phase, so a configuration write never cuts a pulse short. Clock stretching, arbitration between masters and data hold timing are left to other logic.

Top module: `scl_timing_gen`

## Requirements
- R1: Folding. While the ratio is 16 or more, it is halved, each bit shifted out is ORed into a sticky round-up flag, and the exponent is incremented. After folding, the flag (0 or 1) is added to the remaining ratio, which gives a folded ratio from 2 to 16.
- R2: From the folded ratio F, the low count is (F >> 1) - 1 and the high count is F - low - 2.
- R3: `cfg_word_o` equals 0xFFF00300 ORed with the high count in bits 19:16, the low count in bits 15:12 and the exponent in bits 3:0. It updates on the clock edge after a valid `cfg_we_i` and at no other time.
- R4: `hs_mode_o` is 1 exactly when ratio × 400000 < PCLK_HZ, meaning the bus rate is above 400 kHz. `tmo_ctl_o` is 3 while `hs_mode_o` is 1 and 0 otherwise. Both update together with `cfg_word_o`.
- R5: A write with ratio 0 or 1 (no valid bus rate) is rejected. `cfg_word_o`, `hs_mode_o` and `tmo_ctl_o` keep their previous values.
- R6: After reset, `cfg_word_o` = 0xFFF00300, `hs_mode_o` = 0, `tmo_ctl_o` = 0, `scl_o` = 1, `scl_oe_o` = 0, and both strobes are 0.
- R7: While running, SCL is low for (low+1)·2^exp clocks and high for (high+1)·2^exp clocks. One period is therefore F·2^exp clocks.
- R8: A configuration written while SCL runs does not change the current period. It applies from the next falling edge.
- R9: `scl_fall_o` is high for exactly the one cycle in which `scl_o` has just fallen. `scl_rise_o` is high for exactly the one cycle in which it has just risen. The two strobes are never high together.
- R10: When `run_i` is sampled high while idle, the first falling edge and its strobe appear one cycle later. When `run_i` is low at the end of a high phase, the block goes idle with `scl_oe_o` = 0 and `scl_o` = 1, so the period in progress always completes. `scl_o` is 1 whenever `scl_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load strobe for `ratio_i` |
| ratio_i | input | RATIO_W | Peripheral clock cycles per bus clock period |
| run_i | input | 1 | Keep the SCL waveform running |
| cfg_word_o | output | 32 | Packed timing word |
| hs_mode_o | output | 1 | Bus rate above 400 kHz |
| tmo_ctl_o | output | 2 | Timeout control: 3 in high-speed mode, else 0 |
| scl_o | output | 1 | SCL level |
| scl_oe_o | output | 1 | SCL driven (generator active) |
| scl_rise_o | output | 1 | One-cycle strobe after an SCL rising edge |
| scl_fall_o | output | 1 | One-cycle strobe after an SCL falling edge |

## Verification
The assertions check, on every cycle, the following local rules:
- Each strobe matches an actual edge of `scl_o`.
- Activation always begins with a falling strobe.
- SCL is released whenever the generator is idle.
- The timing word changes only after a write, and never after a rejected one.
- The timeout control follows the high-speed flag.

The arithmetic itself can only be shown by the bench's sweeps:
- The folded exponent, low count and high count across every small ratio and several large ones.
- The measured low and period lengths in clock cycles.
- The deferral of a mid-period reconfiguration to the next low phase.
- The complete final period after run is dropped.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;
  localparam logic [31:0] CFG_BASE = 32'hFFF0_0300;
  localparam int unsigned HI_LSB   = 16;
  localparam int unsigned LO_LSB   = 12;
  localparam int unsigned EXP_LSB  = 0;
  localparam int unsigned FOLD_LIM = 16;

  typedef struct packed {
    logic [3:0] exp;
    logic [3:0] lo;
    logic [3:0] hi;
  } scl_timing_t;
endpackage

// File: rtl/scl_ratio_fold.sv
module scl_ratio_fold
  import scl_timing_pkg::*;
#(
  parameter int unsigned RATIO_W = 16
) (
  input  logic [RATIO_W-1:0] ratio_i,
  output scl_timing_t        timing_o
);
  localparam int unsigned STAGES = RATIO_W - 4;

  logic [RATIO_W-1:0] r_s      [STAGES+1];
  logic               sticky_s [STAGES+1];
  logic [3:0]         exp_s    [STAGES+1];

  assign r_s[0]      = ratio_i;
  assign sticky_s[0] = 1'b0;
  assign exp_s[0]    = 4'd0;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic big;
    assign big           = (r_s[g] >= RATIO_W'(FOLD_LIM));
    assign r_s[g+1]      = big ? (r_s[g] >> 1) : r_s[g];
    assign sticky_s[g+1] = sticky_s[g] | (big & r_s[g][0]);
    assign exp_s[g+1]    = big ? exp_s[g] + 4'd1 : exp_s[g];
  end

  // residue is below 16 after the last stage; round-up may reach 16
  logic [4:0] folded, lo_w, hi_w;
  assign folded = {1'b0, r_s[STAGES][3:0]} + {4'd0, sticky_s[STAGES]};
  assign lo_w   = (folded >> 1) - 5'd1;
  assign hi_w   = folded - lo_w - 5'd2;

  assign timing_o.exp = exp_s[STAGES];
  assign timing_o.lo  = lo_w[3:0];
  assign timing_o.hi  = hi_w[3:0];
endmodule

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
  import scl_timing_pkg::*;
#(
  parameter int unsigned RATIO_W = 16,
  parameter int unsigned PCLK_HZ = 24_000_000,
  parameter int unsigned HS_HZ   = 400_000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  scl_timing_t        timing_i,
  output scl_timing_t        timing_o,
  output logic               hs_o
);
  // ratio*HS_HZ < PCLK_HZ  <=>  ratio < ceil(PCLK_HZ/HS_HZ)
  localparam longint unsigned HS_LIM = (longint'(PCLK_HZ) + HS_HZ - 1) / HS_HZ;

  logic valid, hs_d;
  assign valid = (ratio_i >= RATIO_W'(2));
  assign hs_d  = (64'(ratio_i) < HS_LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timing_o <= '0;
      hs_o     <= 1'b0;
    end else if (cfg_we_i && valid) begin
      timing_o <= timing_i;
      hs_o     <= hs_d;
    end
  end
endmodule

// File: rtl/scl_wave_gen.sv
module scl_wave_gen
  import scl_timing_pkg::*;
#(
  parameter int unsigned PRESC_W = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        run_i,
  input  scl_timing_t timing_i,
  output logic        scl_o,
  output logic        scl_oe_o,
  output logic        rise_o,
  output logic        fall_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} wave_st_e;

  wave_st_e           st_q;
  scl_timing_t        act_q;
  logic [PRESC_W-1:0] presc_q;
  logic [3:0]         cnt_q;
  logic [PRESC_W:0]   presc_lim;
  logic               tick;

  assign presc_lim = ((PRESC_W+1)'(1) << act_q.exp) - (PRESC_W+1)'(1);
  assign tick      = (presc_q == presc_lim[PRESC_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      act_q   <= '0;
      presc_q <= '0;
      cnt_q   <= '0;
      rise_o  <= 1'b0;
      fall_o  <= 1'b0;
    end else begin
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (run_i) begin
          st_q    <= ST_LOW;
          act_q   <= timing_i;
          presc_q <= '0;
          cnt_q   <= '0;
          fall_o  <= 1'b1;
        end
        ST_LOW: begin
          if (!tick) presc_q <= presc_q + 1'b1;
          else begin
            presc_q <= '0;
            if (cnt_q == act_q.lo) begin
              st_q   <= ST_HIGH;
              cnt_q  <= '0;
              rise_o <= 1'b1;
            end else cnt_q <= cnt_q + 4'd1;
          end
        end
        ST_HIGH: begin
          if (!tick) presc_q <= presc_q + 1'b1;
          else begin
            presc_q <= '0;
            cnt_q   <= '0;
            if (cnt_q != act_q.hi) cnt_q <= cnt_q + 4'd1;
            else if (run_i) begin
              st_q   <= ST_LOW;
              act_q  <= timing_i;  // new timing only at low-phase start
              fall_o <= 1'b1;
            end else st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign scl_o    = (st_q != ST_LOW);
  assign scl_oe_o = (st_q != ST_IDLE);
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int unsigned RATIO_W = 16,
  parameter int unsigned PCLK_HZ = 24_000_000,
  parameter int unsigned HS_HZ   = 400_000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               run_i,
  output logic [31:0]        cfg_word_o,
  output logic               hs_mode_o,
  output logic [1:0]         tmo_ctl_o,
  output logic               scl_o,
  output logic               scl_oe_o,
  output logic               scl_rise_o,
  output logic               scl_fall_o
);
  localparam int unsigned PRESC_W = RATIO_W - 4;

  scl_timing_t fold_t, shadow_t;

  scl_ratio_fold #(.RATIO_W(RATIO_W)) u_fold (
    .ratio_i  (ratio_i),
    .timing_o (fold_t)
  );

  scl_cfg_regs #(.RATIO_W(RATIO_W), .PCLK_HZ(PCLK_HZ), .HS_HZ(HS_HZ)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_we_i (cfg_we_i),
    .ratio_i  (ratio_i),
    .timing_i (fold_t),
    .timing_o (shadow_t),
    .hs_o     (hs_mode_o)
  );

  scl_wave_gen #(.PRESC_W(PRESC_W)) u_wave (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .timing_i (shadow_t),
    .scl_o    (scl_o),
    .scl_oe_o (scl_oe_o),
    .rise_o   (scl_rise_o),
    .fall_o   (scl_fall_o)
  );

  assign cfg_word_o = CFG_BASE
                    | (32'(shadow_t.hi)  << HI_LSB)
                    | (32'(shadow_t.lo)  << LO_LSB)
                    | (32'(shadow_t.exp) << EXP_LSB);
  assign tmo_ctl_o  = hs_mode_o ? 2'd3 : 2'd0;
endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk #(
  parameter int unsigned RATIO_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_we_i,
  input logic [RATIO_W-1:0] ratio_i,
  input logic [31:0]        cfg_word_o,
  input logic               hs_mode_o,
  input logic [1:0]         tmo_ctl_o,
  input logic               scl_o,
  input logic               scl_oe_o,
  input logic               scl_rise_o,
  input logic               scl_fall_o
);
  assert_strobe_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(scl_rise_o && scl_fall_o));

  assert_fall_matches_edge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> (scl_fall_o == $fell(scl_o)));

  assert_rise_matches_edge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> (scl_rise_o == $rose(scl_o)));

  assert_idle_released_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scl_oe_o |-> scl_o);

  assert_start_with_fall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_o) |-> scl_fall_o);

  assert_word_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cfg_we_i) |-> $stable(cfg_word_o));

  assert_reject_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cfg_we_i) && ($past(ratio_i) < RATIO_W'(2)))
      |-> ($stable(cfg_word_o) && $stable(hs_mode_o)));

  assert_tmo_follows_hs_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_ctl_o == (hs_mode_o ? 2'd3 : 2'd0));
endmodule

bind scl_timing_gen scl_timing_gen_chk #(.RATIO_W(RATIO_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .ratio_i    (ratio_i),
  .cfg_word_o (cfg_word_o),
  .hs_mode_o  (hs_mode_o),
  .tmo_ctl_o  (tmo_ctl_o),
  .scl_o      (scl_o),
  .scl_oe_o   (scl_oe_o),
  .scl_rise_o (scl_rise_o),
  .scl_fall_o (scl_fall_o)
);

// File: tb/scl_timing_gen_test.sv
module scl_timing_gen_test;
  localparam int unsigned RW   = 16;
  localparam longint      PCLK = 24_000_000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [RW-1:0] ratio = '0;
  logic          run = 1'b0;
  logic [31:0]   cfg_word;
  logic          hs_mode, scl, scl_oe, scl_rise, scl_fall;
  logic [1:0]    tmo_ctl;

  int     n_chk = 0;
  int     n_fail = 0;
  longint cyc = 0;

  scl_timing_gen #(.RATIO_W(RW), .PCLK_HZ(PCLK), .HS_HZ(400_000)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .ratio_i(ratio), .run_i(run),
    .cfg_word_o(cfg_word), .hs_mode_o(hs_mode), .tmo_ctl_o(tmo_ctl),
    .scl_o(scl), .scl_oe_o(scl_oe), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void model(input int r_in, output int e, output int lo, output int hi);
    int r = r_in;
    int inc = 0;
    e = 0;
    while (r >= 16) begin
      inc |= r & 1;
      r >>= 1;
      e++;
    end
    r += inc;
    lo = (r >> 1) - 1;
    hi = r - lo - 2;
  endfunction

  function automatic logic [31:0] exp_word(input int r);
    int e, lo, hi;
    model(r, e, lo, hi);
    return 32'hFFF00300 | (32'(hi) << 16) | (32'(lo) << 12) | 32'(e);
  endfunction

  function automatic longint low_len(input int r);
    int e, lo, hi;
    model(r, e, lo, hi);
    return longint'(lo + 1) << e;
  endfunction

  function automatic longint per_len(input int r);
    int e, lo, hi;
    model(r, e, lo, hi);
    return longint'(lo + hi + 2) << e;
  endfunction

  task automatic write_cfg(input int r);
    @(negedge clk);
    cfg_we = 1'b1;
    ratio  = RW'(r);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_edge(input bit want_rise, output longint t);
    do @(negedge clk); while (!(want_rise ? scl_rise : scl_fall));
    t = cyc;
    if (want_rise) check(scl == 1'b1, "R9 level at rise", scl, 1);
    else           check(scl == 1'b0, "R9 level at fall", scl, 0);
  endtask

  logic [31:0] prev_word = 32'hFFF00300;
  bit          prev_hs = 1'b0;

  task automatic sweep_one(input int r);
    logic [31:0] ew;
    bit          eh;
    write_cfg(r);
    if (r < 2) begin
      ew = prev_word;
      eh = prev_hs;
      check(cfg_word == ew, "R5 word kept", cfg_word, ew);
      check(hs_mode == eh, "R5 hs kept", hs_mode, eh);
    end else begin
      ew = exp_word(r);
      eh = (longint'(r) * 400000) < PCLK;
      check(cfg_word == ew, "R1 R2 R3 word", cfg_word, ew);
      check(hs_mode == eh, "R4 hs flag", hs_mode, eh);
    end
    check(tmo_ctl == (eh ? 2'd3 : 2'd0), "R4 tmo", tmo_ctl, eh ? 3 : 0);
    prev_word = ew;
    prev_hs   = eh;
  endtask

  task automatic measure(input int r);
    longint t0, t1, t2, t3;
    int     extra_falls = 0;
    write_cfg(r);
    @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    check(scl_fall == 1'b1, "R10 first fall one cycle after run", scl_fall, 1);
    t0 = cyc;
    wait_edge(1'b1, t1);
    check(t1 - t0 == low_len(r), "R7 low length", t1 - t0, low_len(r));
    wait_edge(1'b0, t2);
    check(t2 - t0 == per_len(r), "R7 period", t2 - t0, per_len(r));
    run = 1'b0;
    do begin
      @(negedge clk);
      if (scl_fall) extra_falls++;
    end while (scl_oe);
    t3 = cyc;
    check(t3 - t2 == per_len(r), "R10 last period completes", t3 - t2, per_len(r));
    check(extra_falls == 0, "R10 no fall after stop", extra_falls, 0);
    check(scl == 1'b1, "R10 released high", scl, 1);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    longint t0, t1, t2, t3, t4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 reset state
    check(cfg_word == 32'hFFF00300, "R6 word", cfg_word, 32'hFFF00300);
    check(hs_mode == 1'b0, "R6 hs", hs_mode, 0);
    check(tmo_ctl == 2'd0, "R6 tmo", tmo_ctl, 0);
    check(scl == 1'b1 && scl_oe == 1'b0, "R6 scl idle", {scl, scl_oe}, 2'b10);
    check(!scl_rise && !scl_fall, "R6 strobes", {scl_rise, scl_fall}, 0);

    for (int r = 0; r < 300; r++) sweep_one(r);
    sweep_one(1);
    foreach (ratio_list[i]) sweep_one(ratio_list[i]);
    sweep_one(0);

    foreach (meas_list[i]) measure(meas_list[i]);

    // R8: mid-period reconfiguration deferred to next low phase
    write_cfg(40);
    @(negedge clk);
    run = 1'b1;
    wait_edge(1'b0, t0);
    write_cfg(20);
    wait_edge(1'b1, t1);
    check(t1 - t0 == low_len(40), "R8 current low unchanged", t1 - t0, low_len(40));
    wait_edge(1'b0, t2);
    check(t2 - t0 == per_len(40), "R8 current period unchanged", t2 - t0, per_len(40));
    wait_edge(1'b1, t3);
    check(t3 - t2 == low_len(20), "R8 new low applied", t3 - t2, low_len(20));
    wait_edge(1'b0, t4);
    check(t4 - t2 == per_len(20), "R8 new period applied", t4 - t2, per_len(20));
    run = 1'b0;
    do @(negedge clk); while (scl_oe);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  int ratio_list[8] = '{1000, 4095, 4096, 4111, 65519, 65535, 59, 60};
  int meas_list[10] = '{2, 3, 15, 16, 17, 31, 33, 100, 250, 1000};
endmodule